// File: doc/BRIEF.md
# Configurable Ripple Arithmetic Slice

This block is an arithmetic slice built from a row of per-bit cells. Every cell forms generate and propagate terms from its two operand bits. From those terms and the ripple bit arriving from the cell below, it produces a result bit and the ripple bit for the cell above. The slice has two layouts. In the full layout the whole width is one carry chain. In the half layout only the lower nibble is a ripple chain, and each upper bit becomes an independent two-input logic function whose four-entry truth table is supplied on a configuration input.

An operation code selects add, subtract or compare. The chain's carry-in comes from one of four selectable sources. Each nibble of the result, and the carry output, may be taken straight from the logic or from registers that share a clock enable and a synchronous reset. A ninth register normally holds the carry. In the half layout it can instead store a general-purpose data bit. The carry is driven on two output ports so that slices can be cascaded. For example, one full-layout slice feeding a half-layout slice through its fast carry input forms a 12-bit adder.

Top module: `rip_slice`

## Requirements
- R1: With op `00` (or `11`, which behaves identically), full layout (`layout_half`=0) and all bypasses selected, `res` equals the low 8 bits of a + b + cin and the carry output equals bit 8 of that sum.
- R2: `cin_sel` picks the chain carry-in: `00` the fast carry input, `01` the general carry input, `10` constant 0, `11` constant 1.
- R3: Op `01` inverts operand b before the chain. With `cin_sel`=`11` in the full layout, `res` equals a − b modulo 256, and the carry is 1 exactly when a ≥ b.
- R4: Op `10` (compare) produces the same carry as op `01`, and the result value is all zeros, both when bypassed and when captured into the result registers.
- R5: In the half layout, `res[3:0]` is the 4-bit ripple result of the lower operand nibbles, and the carry output is taken from bit 3.
- R6: In the half layout with op other than `10`, each upper bit `res[4+i]` equals `lut_cfg[4*i + 2*b[4+i] + a[4+i]]`, using the unmodified operands.
- R7: `reg_res[0]` selects registered output for `res[3:0]` and `reg_res[1]` for `res[7:4]`. The registers capture the combinational result at a clock edge where `ce` is high, and the registered value appears after that edge.
- R8: With `reg_cy`=1 and the general-purpose use not selected, `co_fast`, `co_gen` and `q9` show the carry captured at the most recent enabled edge.
- R9: In the half layout with `gp_sel`=1, the ninth register captures `gp_d` and the carry outputs show the combinational carry. In the full layout `gp_sel` has no effect.
- R10: A clock edge with `rst`=1 clears all result registers and the ninth register, whatever `ce` is. An edge with `ce`=0 and `rst`=0 leaves every register unchanged.
- R11: `co_fast` and `co_gen` always carry the same value. A full slice feeding a half slice's fast carry input yields a correct 12-bit sum and carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of all registers |
| ce | input | 1 | Clock enable for all registers |
| layout_half | input | 1 | 0: full-width chain, 1: split layout |
| op | input | 2 | 00 add, 01 subtract, 10 compare, 11 add |
| cin_sel | input | 2 | Carry-in source select |
| ci_fast | input | 1 | Fast carry input from a neighbouring slice |
| ci_gen | input | 1 | General carry input |
| a | input | 8 | Operand A |
| b | input | 8 | Operand B |
| lut_cfg | input | 16 | Truth tables of the upper bits in the split layout |
| reg_res | input | 2 | Per-nibble result register select |
| reg_cy | input | 1 | Carry register select |
| gp_sel | input | 1 | In split layout, ninth register stores gp_d |
| gp_d | input | 1 | General-purpose data for the ninth register |
| res | output | 8 | Result bits |
| co_fast | output | 1 | Carry output for fast cascading |
| co_gen | output | 1 | Carry output for general routing |
| q9 | output | 1 | Ninth register contents |

## Verification
The hardest situation to reach is a cascade in which the lower slice's carry is registered while the upper slice samples it through its fast input. In that case the upper slice's combinational result depends on a value that changes at the same edge where its own registers capture. The bench reaches it in a long random phase that varies both slices' layouts, bypass selects, enables, general-purpose use and reset pulses independently. A behavioural model tracks both slices' registers, and every output is compared on every clock. Earlier directed phases pin down each carry source, subtraction, compare and the 12-bit cascade sum.

// File: rtl/rip_pkg.sv
package rip_pkg;
    typedef enum logic [1:0] {
        CSRC_FAST = 2'b00,
        CSRC_GEN  = 2'b01,
        CSRC_ZERO = 2'b10,
        CSRC_ONE  = 2'b11
    } csrc_e;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_CMP  = 2'b10,
        OP_ADDX = 2'b11
    } op_e;

    typedef enum logic {
        LAY_FULL = 1'b0,
        LAY_HALF = 1'b1
    } layout_e;
endpackage

// File: rtl/rip_bit_cell.sv
module rip_bit_cell (
    input  logic x,
    input  logic y,
    input  logic rin,
    output logic sum,
    output logic rout
);
    logic gen_t;
    logic prop_t;

    assign gen_t  = x & y;
    assign prop_t = x ^ y;
    assign sum    = prop_t ^ rin;
    assign rout   = gen_t | (prop_t & rin);
endmodule

// File: rtl/rip_carry_chain.sv
module rip_carry_chain #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic [W:0]   rip
);
    assign rip[0] = cin;

    for (genvar k = 0; k < W; k++) begin : g_cell
        rip_bit_cell u_cell (
            .x    (x[k]),
            .y    (y[k]),
            .rin  (rip[k]),
            .sum  (sum[k]),
            .rout (rip[k+1])
        );
    end
endmodule

// File: rtl/rip_lut_bank.sv
module rip_lut_bank #(
    parameter int N = 4
) (
    input  logic [N-1:0]   x,
    input  logic [N-1:0]   y,
    input  logic [4*N-1:0] cfg,
    output logic [N-1:0]   f
);
    for (genvar k = 0; k < N; k++) begin : g_lut
        logic [3:0] table_k;
        assign table_k = cfg[k*4 +: 4];
        assign f[k]    = table_k[{y[k], x[k]}];
    end
endmodule

// File: rtl/rip_out_regs.sv
module rip_out_regs #(
    parameter int NIB_W   = 4,
    parameter int NIBBLES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ce,
    input  logic [NIB_W*NIBBLES-1:0] d_res,
    input  logic                     d_ninth,
    output logic [NIB_W*NIBBLES-1:0] q_res,
    output logic                     q_ninth
);
    for (genvar n = 0; n < NIBBLES; n++) begin : g_nib
        always_ff @(posedge clk) begin
            if (rst) begin
                q_res[n*NIB_W +: NIB_W] <= '0;
            end else if (ce) begin
                q_res[n*NIB_W +: NIB_W] <= d_res[n*NIB_W +: NIB_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_ninth <= 1'b0;
        end else if (ce) begin
            q_ninth <= d_ninth;
        end
    end
endmodule

// File: rtl/rip_slice.sv
module rip_slice #(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ce,
    input  logic               layout_half,
    input  logic [1:0]         op,
    input  logic [1:0]         cin_sel,
    input  logic               ci_fast,
    input  logic               ci_gen,
    input  logic [2*NIB_W-1:0] a,
    input  logic [2*NIB_W-1:0] b,
    input  logic [4*NIB_W-1:0] lut_cfg,
    input  logic [1:0]         reg_res,
    input  logic               reg_cy,
    input  logic               gp_sel,
    input  logic               gp_d,
    output logic [2*NIB_W-1:0] res,
    output logic               co_fast,
    output logic               co_gen,
    output logic               q9
);
    import rip_pkg::*;

    localparam int NIBBLES = 2;
    localparam int W       = NIB_W * NIBBLES;

    csrc_e   src_q;
    op_e     op_q;
    layout_e lay_q;

    logic         chain_cin;
    logic         invert_b;
    logic [W-1:0] b_eff;
    logic [W-1:0] chain_sum;
    logic [W:0]   chain_rip;
    logic [NIB_W-1:0] lut_f;
    logic [W-1:0] comb_res;
    logic         comb_cy;
    logic         gp_use;
    logic         ninth_d;
    logic [W-1:0] q_res;
    logic         q_ninth;
    logic         cy_out;

    assign src_q = csrc_e'(cin_sel);
    assign op_q  = op_e'(op);
    assign lay_q = layout_e'(layout_half);

    always_comb begin
        unique case (src_q)
            CSRC_FAST: chain_cin = ci_fast;
            CSRC_GEN:  chain_cin = ci_gen;
            CSRC_ZERO: chain_cin = 1'b0;
            CSRC_ONE:  chain_cin = 1'b1;
        endcase
    end

    always_comb begin
        unique case (op_q)
            OP_SUB, OP_CMP:  invert_b = 1'b1;
            OP_ADD, OP_ADDX: invert_b = 1'b0;
        endcase
    end

    assign b_eff = invert_b ? ~b : b;

    rip_carry_chain #(.W(W)) u_chain (
        .x   (a),
        .y   (b_eff),
        .cin (chain_cin),
        .sum (chain_sum),
        .rip (chain_rip)
    );

    rip_lut_bank #(.N(NIB_W)) u_luts (
        .x   (a[W-1:NIB_W]),
        .y   (b[W-1:NIB_W]),
        .cfg (lut_cfg),
        .f   (lut_f)
    );

    always_comb begin
        unique case (lay_q)
            LAY_FULL: begin
                comb_res = chain_sum;
                comb_cy  = chain_rip[W];
            end
            LAY_HALF: begin
                comb_res = {lut_f, chain_sum[NIB_W-1:0]};
                comb_cy  = chain_rip[NIB_W];
            end
        endcase
        if (op_q == OP_CMP) begin
            comb_res = '0;
        end
    end

    assign gp_use  = (lay_q == LAY_HALF) && gp_sel;
    assign ninth_d = gp_use ? gp_d : comb_cy;

    rip_out_regs #(.NIB_W(NIB_W), .NIBBLES(NIBBLES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .d_res   (comb_res),
        .d_ninth (ninth_d),
        .q_res   (q_res),
        .q_ninth (q_ninth)
    );

    for (genvar n = 0; n < NIBBLES; n++) begin : g_outsel
        assign res[n*NIB_W +: NIB_W] = reg_res[n] ? q_res[n*NIB_W +: NIB_W]
                                                  : comb_res[n*NIB_W +: NIB_W];
    end

    assign cy_out  = (reg_cy && !gp_use) ? q_ninth : comb_cy;
    assign co_fast = cy_out;
    assign co_gen  = cy_out;
    assign q9      = q_ninth;
endmodule

// File: rtl/rip_slice_chk.sv
module rip_slice_chk #(
    parameter int NIB_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               ce,
    input logic               layout_half,
    input logic [1:0]         op,
    input logic [1:0]         cin_sel,
    input logic [2*NIB_W-1:0] a,
    input logic [2*NIB_W-1:0] b,
    input logic [4*NIB_W-1:0] lut_cfg,
    input logic [1:0]         reg_res,
    input logic               reg_cy,
    input logic               gp_sel,
    input logic               gp_d,
    input logic [2*NIB_W-1:0] res,
    input logic               co_fast,
    input logic               q9
);
    localparam int W = 2 * NIB_W;

    logic [W:0]       s_add;
    logic [NIB_W:0]   s_lo;
    logic [W-1:0]     d_sub;

    assign s_add = {1'b0, a} + {1'b0, b};
    assign s_lo  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]};
    assign d_sub = a - b;

    assert_full_add_R1: assert property (@(posedge clk) disable iff (rst)
        (!layout_half && op == 2'b00 && reg_res == 2'b00 && !reg_cy && cin_sel == 2'b10)
        |-> ({co_fast, res} == s_add));

    assert_sub_R3: assert property (@(posedge clk) disable iff (rst)
        (!layout_half && op == 2'b01 && reg_res == 2'b00 && !reg_cy && cin_sel == 2'b11)
        |-> (res == d_sub && co_fast == (a >= b)));

    assert_cmp_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (op == 2'b10 && reg_res == 2'b00) |-> (res == '0));

    assert_half_chain_R5: assert property (@(posedge clk) disable iff (rst)
        (layout_half && op == 2'b00 && !reg_res[0] && !reg_cy && cin_sel == 2'b10)
        |-> ({co_fast, res[NIB_W-1:0]} == s_lo));

    for (genvar k = 0; k < NIB_W; k++) begin : g_lut_chk
        logic [3:0] tt;
        assign tt = lut_cfg[k*4 +: 4];
        assert_lut_bit_R6: assert property (@(posedge clk) disable iff (rst)
            (layout_half && op != 2'b10 && !reg_res[1])
            |-> (res[NIB_W+k] == tt[{b[NIB_W+k], a[NIB_W+k]}]));
    end

    assert_gp_capture_R9: assert property (@(posedge clk) disable iff (rst)
        (layout_half && gp_sel && ce) |=> (q9 == $past(gp_d)));

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q9 == 1'b0 && (res & {{NIB_W{reg_res[1]}}, {NIB_W{reg_res[0]}}}) == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q9));
endmodule

bind rip_slice rip_slice_chk #(.NIB_W(NIB_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ce          (ce),
    .layout_half (layout_half),
    .op          (op),
    .cin_sel     (cin_sel),
    .a           (a),
    .b           (b),
    .lut_cfg     (lut_cfg),
    .reg_res     (reg_res),
    .reg_cy      (reg_cy),
    .gp_sel      (gp_sel),
    .gp_d        (gp_d),
    .res         (res),
    .co_fast     (co_fast),
    .q9          (q9)
);

// File: tb/tb_rip_slice.sv
module tb_rip_slice;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst;
    logic       s_ce   [2];
    logic       s_lay  [2];
    logic [1:0] s_op   [2];
    logic [1:0] s_src  [2];
    logic       s_cg   [2];
    logic [7:0] s_a    [2];
    logic [7:0] s_b    [2];
    logic [15:0] s_cfg [2];
    logic [1:0] s_rr   [2];
    logic       s_rc   [2];
    logic       s_gs   [2];
    logic       s_gd   [2];
    logic       s_cf0;

    logic [7:0] r0, r1;
    logic cf0, cg0, q0, cf1, cg1, q1;

    rip_slice dut (
        .clk(clk), .rst(rst), .ce(s_ce[0]), .layout_half(s_lay[0]), .op(s_op[0]),
        .cin_sel(s_src[0]), .ci_fast(s_cf0), .ci_gen(s_cg[0]), .a(s_a[0]), .b(s_b[0]),
        .lut_cfg(s_cfg[0]), .reg_res(s_rr[0]), .reg_cy(s_rc[0]), .gp_sel(s_gs[0]),
        .gp_d(s_gd[0]), .res(r0), .co_fast(cf0), .co_gen(cg0), .q9(q0)
    );

    rip_slice u_hi (
        .clk(clk), .rst(rst), .ce(s_ce[1]), .layout_half(s_lay[1]), .op(s_op[1]),
        .cin_sel(s_src[1]), .ci_fast(cf0), .ci_gen(s_cg[1]), .a(s_a[1]), .b(s_b[1]),
        .lut_cfg(s_cfg[1]), .reg_res(s_rr[1]), .reg_cy(s_rc[1]), .gp_sel(s_gs[1]),
        .gp_d(s_gd[1]), .res(r1), .co_fast(cf1), .co_gen(cg1), .q9(q1)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] m_res [2];
    logic       m_q9  [2];
    bit cascade_chk = 0;

    task automatic chk(string tag, string what, int act, int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp_v);
        end
    endtask

    function automatic logic [8:0] model(int k, logic cf);
        int cin, s;
        logic [7:0] bb, rr;
        logic c;
        case (s_src[k])
            2'b00: cin = int'(cf);
            2'b01: cin = int'(s_cg[k]);
            2'b10: cin = 0;
            default: cin = 1;
        endcase
        bb = (s_op[k] == 2'b01 || s_op[k] == 2'b10) ? ~s_b[k] : s_b[k];
        if (!s_lay[k]) begin
            s  = int'(s_a[k]) + int'(bb) + cin;
            rr = s[7:0];
            c  = s[8];
        end else begin
            s  = int'(s_a[k][3:0]) + int'(bb[3:0]) + cin;
            rr[3:0] = s[3:0];
            c  = s[4];
            for (int i = 0; i < 4; i++)
                rr[4+i] = s_cfg[k][4*i + 2*int'(s_b[k][4+i]) + int'(s_a[k][4+i])];
        end
        if (s_op[k] == 2'b10) rr = 8'h00;
        return {c, rr};
    endfunction

    task automatic step(string tag);
        logic [8:0] c0, c1;
        logic [7:0] e0, e1;
        logic x0, x1;
        logic gu0, gu1;
        #2;
        c0  = model(0, s_cf0);
        gu0 = s_lay[0] && s_gs[0];
        e0  = {s_rr[0][1] ? m_res[0][7:4] : c0[7:4], s_rr[0][0] ? m_res[0][3:0] : c0[3:0]};
        x0  = (s_rc[0] && !gu0) ? m_q9[0] : c0[8];
        c1  = model(1, x0);
        gu1 = s_lay[1] && s_gs[1];
        e1  = {s_rr[1][1] ? m_res[1][7:4] : c1[7:4], s_rr[1][0] ? m_res[1][3:0] : c1[3:0]};
        x1  = (s_rc[1] && !gu1) ? m_q9[1] : c1[8];
        chk(tag, "lo res", int'(r0), int'(e0));
        chk(tag, "lo co_fast", int'(cf0), int'(x0));
        chk("R11", "lo co_gen", int'(cg0), int'(x0));
        chk(tag, "lo q9", int'(q0), int'(m_q9[0]));
        chk(tag, "hi res", int'(r1), int'(e1));
        chk(tag, "hi co_fast", int'(cf1), int'(x1));
        chk("R11", "hi co_gen", int'(cg1), int'(x1));
        chk(tag, "hi q9", int'(q1), int'(m_q9[1]));
        if (cascade_chk) begin
            int cin, sum12;
            cin = (s_src[0] == 2'b11) ? 1 : (s_src[0] == 2'b01) ? int'(s_cg[0]) :
                  (s_src[0] == 2'b00) ? int'(s_cf0) : 0;
            sum12 = int'({s_a[1][3:0], s_a[0]}) + int'({s_b[1][3:0], s_b[0]}) + cin;
            chk("R11", "12-bit sum", int'({cf1, r1[3:0], r0}), sum12);
        end
        @(posedge clk);
        if (rst) begin
            m_res[0] = '0; m_res[1] = '0; m_q9[0] = 1'b0; m_q9[1] = 1'b0;
        end else begin
            if (s_ce[0]) begin m_res[0] = c0[7:0]; m_q9[0] = gu0 ? s_gd[0] : c0[8]; end
            if (s_ce[1]) begin m_res[1] = c1[7:0]; m_q9[1] = gu1 ? s_gd[1] : c1[8]; end
        end
        @(negedge clk);
    endtask

    task automatic rnd_ops(int k);
        s_a[k] = 8'($urandom); s_b[k] = 8'($urandom);
        s_cg[k] = 1'($urandom);
        s_cfg[k] = 16'($urandom);
        s_gd[k] = 1'($urandom);
    endtask

    task automatic plain(int k);
        s_ce[k] = 1'b1; s_lay[k] = 1'b0; s_op[k] = 2'b00; s_src[k] = 2'b10;
        s_rr[k] = 2'b00; s_rc[k] = 1'b0; s_gs[k] = 1'b0;
        rnd_ops(k);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; s_cf0 = 1'b0;
        m_res[0] = '0; m_res[1] = '0; m_q9[0] = 1'b0; m_q9[1] = 1'b0;
        for (int k = 0; k < 2; k++) begin plain(k); s_rr[k] = 2'b11; s_rc[k] = 1'b1; end
        @(negedge clk);
        // R10: reset state with all registers selected
        for (int i = 0; i < 3; i++) step("R10");
        rst = 1'b0;

        // R1/R2: full add, every carry source, with 12-bit cascade
        cascade_chk = 1;
        for (int i = 0; i < 200; i++) begin
            plain(0); plain(1);
            s_lay[1] = 1'b1; s_src[1] = 2'b00; s_op[1] = (i % 2 == 0) ? 2'b00 : 2'b11;
            s_src[0] = 2'(i % 4); s_cf0 = 1'($urandom);
            if (i == 0) begin s_a[0] = 8'hFF; s_b[0] = 8'h01; s_a[1] = 8'h0F; s_b[1] = 8'h00; end
            step((i % 4 == 0) ? "R2" : "R1");
        end
        cascade_chk = 0;

        // R3: subtract with constant-one carry-in, including equal operands
        for (int i = 0; i < 100; i++) begin
            plain(0); plain(1);
            s_op[0] = 2'b01; s_src[0] = 2'b11;
            if (i < 4) s_b[0] = s_a[0];
            step("R3");
        end

        // R4: compare, bypass and registered results
        for (int i = 0; i < 60; i++) begin
            plain(0); plain(1);
            s_op[0] = 2'b10; s_src[0] = 2'b11; s_rr[0] = 2'(i % 4);
            s_op[1] = 2'b10; s_src[1] = 2'(i % 4);
            step("R4");
        end

        // R5/R6: split layout, lower ripple and upper truth tables
        for (int i = 0; i < 150; i++) begin
            plain(0); plain(1);
            s_lay[0] = 1'b1; s_lay[1] = 1'b1;
            s_op[0] = 2'(i % 2); s_src[0] = 2'(i % 4); s_cf0 = 1'($urandom);
            s_src[1] = 2'b00;
            step((i % 2 == 0) ? "R5" : "R6");
        end

        // R9: general-purpose ninth register in split layout, ignored in full
        for (int i = 0; i < 60; i++) begin
            plain(0); plain(1);
            s_lay[0] = 1'(i % 2); s_gs[0] = 1'b1; s_rc[0] = 1'b1;
            s_lay[1] = 1'b1; s_gs[1] = 1'b1; s_src[1] = 2'b00;
            step("R9");
        end

        // R7/R8/R10: random registered operation, enables and resets
        for (int i = 0; i < 500; i++) begin
            for (int k = 0; k < 2; k++) begin
                rnd_ops(k);
                s_ce[k] = ($urandom % 4) != 0; s_lay[k] = 1'($urandom);
                s_op[k] = 2'($urandom); s_src[k] = 2'($urandom);
                s_rr[k] = 2'($urandom); s_rc[k] = 1'($urandom); s_gs[k] = 1'($urandom);
            end
            s_cf0 = 1'($urandom);
            rst = ($urandom % 25) == 0;
            step((i % 3 == 0) ? "R7" : (i % 3 == 1) ? "R8" : "R10");
        end
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule